// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits in the decode stage of an in-order core that can issue two instructions per cycle. Each cycle it receives two decoded descriptors in program order. The first is the older instruction and is bound for the primary (U) pipe. The second is the candidate for the secondary (V) pipe. The block decides whether the older instruction issues alone or whether both issue together. When it refuses a pair, it also reports one reason for the refusal.

A descriptor carries the following fields:
- a valid bit;
- a 3-bit class code;
- a microcoded flag;
- two source register indices, each with a valid bit;
- a destination register index with a valid bit;
- a flag-write bit and a flag-read bit.

Pairing depends on four things: which units each pipe has, register hazards other than write-after-read, a special case that lets a compare pair with a conditional branch, and a rule that nothing may follow a jump in the same cycle. A parameter chooses whether the decision is registered (one cycle of latency) or purely combinational.

Top module: `pair_issue_check`

## Requirements
- R1: The class codes are ALU=0, CMP=1, MEM=2, JMP=3 and SHIFT=4. Codes 5 to 7, or a set microcoded flag, make an instruction non-simple. If either valid slot holds a non-simple instruction, only U issues and the reason is not_simple.
- R2: A SHIFT-class instruction in the second slot blocks pairing with reason v_class. SHIFT in the first slot may still pair.
- R3: If a valid V source register equals the valid U destination register, pairing is refused with reason raw.
- R4: If the V and U destinations are both valid and equal, pairing is refused with reason waw.
- R5: A V destination equal to a U source register does not block pairing.
- R6: If V reads flags that U writes, pairing is refused with reason flags. The one exception is a CMP-class U with a JMP-class V, which may still pair.
- R7: If U is JMP-class, V never issues, and the reason is u_jump.
- R8: The reason is one-hot: bit0 none, bit1 not_simple, bit2 v_class, bit3 raw, bit4 waw, bit5 flags, bit6 u_jump. When several refusal causes apply, the lowest-numbered bit among them wins.
- R9: If the first slot is invalid, nothing issues. If only the first slot is valid, only U issues. In both cases the reason is none.
- R10: With OUT_REG=1, the outputs reflect the inputs of the previous clock edge. During reset, both issue outputs are 0 and the reason is none.
- R11: issue_v is never asserted without issue_u, and a paired issue always reports reason none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| u_vld | input | 1 | First slot valid |
| u_cls | input | 3 | First slot class code |
| u_ucode | input | 1 | First slot is microcoded |
| u_src0 | input | REG_W | First slot source 0 |
| u_src0_vld | input | 1 | Source 0 used |
| u_src1 | input | REG_W | First slot source 1 |
| u_src1_vld | input | 1 | Source 1 used |
| u_dst | input | REG_W | First slot destination |
| u_dst_vld | input | 1 | Destination written |
| u_fwr | input | 1 | First slot writes flags |
| u_frd | input | 1 | First slot reads flags |
| v_vld | input | 1 | Second slot valid |
| v_cls | input | 3 | Second slot class code |
| v_ucode | input | 1 | Second slot is microcoded |
| v_src0 | input | REG_W | Second slot source 0 |
| v_src0_vld | input | 1 | Source 0 used |
| v_src1 | input | REG_W | Second slot source 1 |
| v_src1_vld | input | 1 | Source 1 used |
| v_dst | input | REG_W | Second slot destination |
| v_dst_vld | input | 1 | Destination written |
| v_fwr | input | 1 | Second slot writes flags |
| v_frd | input | 1 | Second slot reads flags |
| issue_u | output | 1 | Issue the first slot to U |
| issue_v | output | 1 | Issue the second slot to V |
| reason | output | 7 | One-hot refusal reason |

## Verification
Several refusal causes often hold in the same cycle, so the interesting collisions are between them. The main case is a jump in U whose V partner also has a register hazard or a flag dependency. Directed pairs are built to hit exactly those overlaps: RAW together with WAW, flags together with u_jump, and a shifter in V together with RAW. In each case the reported reason must be the higher-priority cause. Random pairs use a small register file, so index collisions are frequent. Each result is judged against an independent priority model, one cycle after the pair is driven.

// File: rtl/pair_issue_check.sv
module pair_issue_check #(
  parameter int REG_W   = 3,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             u_vld,
  input  logic [2:0]       u_cls,
  input  logic             u_ucode,
  input  logic [REG_W-1:0] u_src0,
  input  logic             u_src0_vld,
  input  logic [REG_W-1:0] u_src1,
  input  logic             u_src1_vld,
  input  logic [REG_W-1:0] u_dst,
  input  logic             u_dst_vld,
  input  logic             u_fwr,
  input  logic             u_frd,
  input  logic             v_vld,
  input  logic [2:0]       v_cls,
  input  logic             v_ucode,
  input  logic [REG_W-1:0] v_src0,
  input  logic             v_src0_vld,
  input  logic [REG_W-1:0] v_src1,
  input  logic             v_src1_vld,
  input  logic [REG_W-1:0] v_dst,
  input  logic             v_dst_vld,
  input  logic             v_fwr,
  input  logic             v_frd,
  output logic             issue_u,
  output logic             issue_v,
  output logic [6:0]       reason
);
  localparam logic [2:0] CL_CMP = 3'd1;
  localparam logic [2:0] CL_JMP = 3'd3;
  localparam logic [2:0] CL_SHF = 3'd4;

  localparam logic [6:0] RS_NONE = 7'b0000001;
  localparam logic [6:0] RS_NSIM = 7'b0000010;
  localparam logic [6:0] RS_VCLS = 7'b0000100;
  localparam logic [6:0] RS_RAW  = 7'b0001000;
  localparam logic [6:0] RS_WAW  = 7'b0010000;
  localparam logic [6:0] RS_FLG  = 7'b0100000;
  localparam logic [6:0] RS_UJMP = 7'b1000000;

  logic u_simple, v_simple, raw_hit, waw_hit, flg_hit, u_is_jmp;
  logic nx_u, nx_v;
  logic [6:0] nx_rsn;
  logic unused_in;

  assign u_simple = !u_ucode && (u_cls <= CL_SHF);
  assign v_simple = !v_ucode && (v_cls <= CL_SHF);
  assign raw_hit  = u_dst_vld && ((v_src0_vld && v_src0 == u_dst) ||
                                  (v_src1_vld && v_src1 == u_dst));
  assign waw_hit  = u_dst_vld && v_dst_vld && (v_dst == u_dst);
  assign flg_hit  = u_fwr && v_frd && !(u_cls == CL_CMP && v_cls == CL_JMP);
  assign u_is_jmp = (u_cls == CL_JMP);

  assign unused_in = ^{u_src0, u_src0_vld, u_src1, u_src1_vld, u_frd, v_fwr};

  always_comb begin
    nx_u   = u_vld;
    nx_v   = 1'b0;
    nx_rsn = RS_NONE;
    if (u_vld && v_vld) begin
      if (!u_simple || !v_simple) nx_rsn = RS_NSIM;
      else if (v_cls == CL_SHF)   nx_rsn = RS_VCLS;
      else if (raw_hit)           nx_rsn = RS_RAW;
      else if (waw_hit)           nx_rsn = RS_WAW;
      else if (flg_hit)           nx_rsn = RS_FLG;
      else if (u_is_jmp)          nx_rsn = RS_UJMP;
      else                        nx_v   = 1'b1;
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          issue_u <= 1'b0;
          issue_v <= 1'b0;
          reason  <= RS_NONE;
        end else begin
          issue_u <= nx_u;
          issue_v <= nx_v;
          reason  <= nx_rsn;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign issue_u = nx_u;
      assign issue_v = nx_v;
      assign reason  = nx_rsn;
    end
  endgenerate
endmodule

// File: rtl/pair_issue_check_chk.sv
module pair_issue_check_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       u_vld,
  input logic [2:0] u_cls,
  input logic       v_vld,
  input logic       issue_u,
  input logic       issue_v,
  input logic [6:0] reason
);
  // R8
  reason_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reason) == 1);

  // R11
  v_needs_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> issue_u);

  // R11
  pair_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> reason[0]);

  generate
    if (OUT_REG) begin : g_seq
      // R7
      no_v_after_jmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (u_vld && u_cls == 3'd3) |=> !issue_v);
      // R9
      idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !u_vld |=> (!issue_u && reason[0]));
      // R9
      single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (u_vld && !v_vld) |=> (issue_u && !issue_v && reason[0]));
    end else begin : g_cmb
      always_comb begin
        if (rst_n) begin
          // R7
          no_v_after_jmp_chk: assert (!(u_vld && u_cls == 3'd3 && issue_v));
          // R9
          idle_slot_chk: assert (u_vld || !issue_u);
        end
      end
    end
  endgenerate
endmodule

bind pair_issue_check pair_issue_check_chk #(.OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst_n(rst_n), .u_vld(u_vld), .u_cls(u_cls), .v_vld(v_vld),
  .issue_u(issue_u), .issue_v(issue_v), .reason(reason)
);

// File: tb/pair_issue_check_tb_top.sv
module pair_issue_check_tb_top;
  localparam int RW = 3;

  typedef struct packed {
    logic          vld;
    logic [2:0]    cls;
    logic          uc;
    logic [RW-1:0] s0;
    logic          s0v;
    logic [RW-1:0] s1;
    logic          s1v;
    logic [RW-1:0] d;
    logic          dv;
    logic          fw;
    logic          fr;
  } desc_t;

  typedef struct {
    logic       iu;
    logic       iv;
    logic [6:0] rs;
    string      tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  desc_t ua = '0, va = '0;
  logic issue_u, issue_v;
  logic [6:0] reason;
  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  pair_issue_check #(.REG_W(RW), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .u_vld(ua.vld), .u_cls(ua.cls), .u_ucode(ua.uc),
    .u_src0(ua.s0), .u_src0_vld(ua.s0v), .u_src1(ua.s1), .u_src1_vld(ua.s1v),
    .u_dst(ua.d), .u_dst_vld(ua.dv), .u_fwr(ua.fw), .u_frd(ua.fr),
    .v_vld(va.vld), .v_cls(va.cls), .v_ucode(va.uc),
    .v_src0(va.s0), .v_src0_vld(va.s0v), .v_src1(va.s1), .v_src1_vld(va.s1v),
    .v_dst(va.d), .v_dst_vld(va.dv), .v_fwr(va.fw), .v_frd(va.fr),
    .issue_u(issue_u), .issue_v(issue_v), .reason(reason)
  );

  function automatic desc_t mk(logic [2:0] cls, logic uc, int s0, logic s0v,
                               int s1, logic s1v, int d, logic dv, logic fw, logic fr);
    desc_t x;
    x.vld = 1; x.cls = cls; x.uc = uc;
    x.s0 = RW'(s0); x.s0v = s0v; x.s1 = RW'(s1); x.s1v = s1v;
    x.d = RW'(d); x.dv = dv; x.fw = fw; x.fr = fr;
    return x;
  endfunction

  function automatic exp_t model(desc_t a, desc_t b);
    exp_t e;
    bit sa, sb;
    e.iu = a.vld; e.iv = 0; e.rs = 7'b0000001;
    if (!(a.vld && b.vld)) return e;
    sa = !a.uc && a.cls <= 4;
    sb = !b.uc && b.cls <= 4;
    if (!sa || !sb) e.rs = 7'b0000010;
    else if (b.cls == 4) e.rs = 7'b0000100;
    else if (a.dv && ((b.s0v && b.s0 == a.d) || (b.s1v && b.s1 == a.d))) e.rs = 7'b0001000;
    else if (a.dv && b.dv && a.d == b.d) e.rs = 7'b0010000;
    else if (a.fw && b.fr && !(a.cls == 1 && b.cls == 3)) e.rs = 7'b0100000;
    else if (a.cls == 3) e.rs = 7'b1000000;
    else e.iv = 1;
    return e;
  endfunction

  task automatic send(desc_t a, desc_t b, string tag);
    exp_t e;
    @(negedge clk);
    ua = a; va = b;
    e = model(a, b);
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (issue_u !== e.iu || issue_v !== e.iv || reason !== e.rs) begin
          errors++;
          $display("FAIL %s: got u=%b v=%b rs=%b exp u=%b v=%b rs=%b",
                   e.tag, issue_u, issue_v, reason, e.iu, e.iv, e.rs);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hang exp completion");
    finish_run();
  end

  initial begin
    desc_t n, alu, sh;
    n = '0;
    repeat (3) @(negedge clk);
    checks++; // R10 reset state
    if (issue_u !== 0 || issue_v !== 0 || reason !== 7'b0000001) begin
      errors++;
      $display("FAIL R10: got u=%b v=%b rs=%b exp 0 0 0000001", issue_u, issue_v, reason);
    end
    rst_n = 1;
    alu = mk(0, 0, 1, 1, 2, 1, 3, 1, 0, 0);
    sh  = mk(4, 0, 4, 1, 0, 0, 5, 1, 0, 0);
    send(alu, mk(0, 0, 4, 1, 5, 1, 6, 1, 0, 0), "R11");
    send(mk(0, 1, 1, 1, 2, 1, 3, 1, 0, 0), alu, "R1");
    send(alu, mk(7, 0, 0, 0, 0, 0, 6, 1, 0, 0), "R1");
    send(alu, mk(2, 1, 0, 0, 0, 0, 6, 1, 0, 0), "R1");
    send(sh, alu, "R2");
    send(alu, sh, "R2");
    send(alu, mk(2, 0, 0, 0, 3, 1, 6, 1, 0, 0), "R3");
    send(alu, mk(0, 0, 3, 0, 3, 0, 6, 1, 0, 0), "R3");
    send(alu, mk(2, 0, 5, 1, 0, 0, 3, 1, 0, 0), "R4");
    send(alu, mk(0, 0, 5, 1, 0, 0, 1, 1, 0, 0), "R5");
    send(mk(1, 0, 1, 1, 2, 1, 0, 0, 1, 0), mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 1), "R6");
    send(mk(0, 0, 1, 1, 2, 1, 3, 1, 1, 0), mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 1), "R6");
    send(mk(1, 0, 1, 1, 2, 1, 0, 0, 1, 0), mk(0, 0, 5, 1, 0, 0, 6, 1, 0, 1), "R6");
    send(mk(3, 0, 1, 1, 0, 0, 0, 0, 0, 0), alu, "R7");
    send(mk(3, 0, 1, 1, 0, 0, 2, 1, 1, 0), mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 1), "R8");
    send(alu, mk(0, 0, 3, 1, 0, 0, 3, 1, 0, 0), "R8");
    send(alu, mk(4, 0, 3, 1, 0, 0, 3, 1, 0, 0), "R8");
    send(mk(3, 0, 0, 0, 0, 0, 3, 1, 0, 0), mk(0, 0, 3, 1, 0, 0, 7, 1, 0, 0), "R8");
    send(alu, n, "R9");
    send(mk(0, 1, 0, 0, 0, 0, 0, 0, 0, 0), n, "R9");
    send(n, alu, "R9");
    send(alu, mk(0, 0, 4, 1, 5, 1, 6, 1, 0, 0), "R10");
    for (int i = 0; i < 4000; i++) begin
      desc_t a, b;
      a = desc_t'($urandom);
      b = desc_t'($urandom);
      a.vld = ($urandom % 8) != 0;
      b.vld = ($urandom % 8) != 0;
      a.uc  = ($urandom % 8) == 0;
      b.uc  = ($urandom % 8) == 0;
      send(a, b, "R8");
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule